// File: doc/BRIEF.md
# I2C Transfer Sequencer

This engine runs a complete I2C master read or write transaction on top of a byte-level master controller that reports its progress as status codes. A request carries a 7-bit target address, a direction and a byte count. The engine asks the controller for a start condition. It then responds to each completion event the controller raises, according to the status code that comes with it.

In a write, the engine pulls bytes from a ready/valid byte stream and loads them into the controller. In a read, it sets or clears the controller's acknowledge level and emits each received byte as a one-cycle pulse on an output stream. When the transaction ends, the engine asks for a stop condition and pulses done. It also presents the number of bytes moved and an error flag. Both stay valid until the next request is accepted. A status code that the engine does not expect for the current direction ends the transaction with an error. Bit-level bus timing stays inside the master controller.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A request on `req_valid` is accepted only while `busy` is low. The cycle after acceptance, `ctl_start` pulses for one cycle and `busy` goes high. `busy` stays high until the cycle in which `done` pulses.
- R2: A completion event with status 0x08 makes `ctl_load` pulse with `ctl_wdata` = {address[6:0], dir}, where dir is 1 for read and 0 for write.
- R3: In a write, status 0x18 or 0x28 with bytes still to send raises `tx_ready` until `tx_valid` is seen. The cycle after that handshake, `ctl_load` pulses with the accepted byte.
- R4: In a write, status 0x18 or 0x28 with no bytes left pulses `ctl_stop` and `done`, with `err` = 0 and `xfer_count` = the requested length.
- R5: A zero-length write loads only the address byte. Its next status (0x18) ends the transaction with `xfer_count` = 0 and `tx_ready` never raised.
- R6: In a read, status 0x40 drives `ctl_ack` high.
- R7: In a read, status 0x50 with room left pulses `rx_valid` with `rx_data` = `ctl_rdata` and keeps `ctl_ack` high. With no room left, it clears `ctl_ack`, gives no `rx_valid` pulse and leaves the count unchanged.
- R8: In a read, status 0x58 pulses `ctl_stop` and `done`, with `err` = 0 and `xfer_count` = the number of bytes delivered.
- R9: Any other status for the current direction pulses `ctl_stop` and `done` with `err` = 1. For example, 0x40 during a write, 0x18 during a read, or 0x20, 0x30 or 0x48. `xfer_count` then equals the bytes loaded (write) or delivered (read) so far.
- R10: `done` lasts one cycle and coincides with `ctl_stop`. `err` and `xfer_count` hold their end values until the next request is accepted, which clears both.
- R11: A request raised while `busy` is high is ignored: no `ctl_start` pulse, and the running transaction completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request |
| req_addr | input | 7 | Target device address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Transaction ended on an unexpected status |
| xfer_count | output | LEN_W | Bytes actually moved |
| tx_valid | input | 1 | Write byte available |
| tx_data | input | 8 | Write byte |
| tx_ready | output | 1 | Engine takes a write byte |
| rx_valid | output | 1 | Read byte pulse |
| rx_data | output | 8 | Read byte |
| ctl_start | output | 1 | Start-condition request pulse to the controller |
| ctl_stop | output | 1 | Stop-condition request pulse to the controller |
| ctl_ack | output | 1 | Acknowledge level for received bytes |
| ctl_load | output | 1 | Load pulse for `ctl_wdata` |
| ctl_wdata | output | 8 | Byte to transmit |
| ctl_event | input | 1 | Controller completion event |
| ctl_status | input | 8 | Status code of the event |
| ctl_rdata | input | 8 | Byte received by the controller |

## Verification
The bench builds the engine with LEN_W = 4. This keeps the longest burst at 15 bytes, so a maximum-length write runs in a few hundred cycles. The count is driven from zero up to its full-scale value. With this width, both the zero-length and the full-length cases are cheap to run. Mid-transfer faults can be injected at any byte position in both directions.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam logic [7:0] ST_STARTED   = 8'h08;
  localparam logic [7:0] ST_WADDR_ACK = 8'h18;
  localparam logic [7:0] ST_WDATA_ACK = 8'h28;
  localparam logic [7:0] ST_RADDR_ACK = 8'h40;
  localparam logic [7:0] ST_RDATA_ACK = 8'h50;
  localparam logic [7:0] ST_RDATA_NAK = 8'h58;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_FETCH} sq_state_e;

  typedef enum logic [2:0] {
    ACT_ADDR, ACT_SEND, ACT_END, ACT_ACK_ON, ACT_RX_KEEP, ACT_RX_DROP, ACT_FAULT
  } sq_act_e;
endpackage

// File: rtl/i2c_seq_rst_sync.sv
module i2c_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
  import i2c_seq_pkg::*;
(
  input  logic [7:0] status,
  input  logic       is_read,
  input  logic       room,
  output sq_act_e    act
);
  always_comb begin
    act = ACT_FAULT;
    if (status == ST_STARTED) begin
      act = ACT_ADDR;
    end else if (!is_read) begin
      if (status == ST_WADDR_ACK || status == ST_WDATA_ACK)
        act = room ? ACT_SEND : ACT_END;
    end else begin
      case (status)
        ST_RADDR_ACK: act = ACT_ACK_ON;
        ST_RDATA_ACK: act = room ? ACT_RX_KEEP : ACT_RX_DROP;
        ST_RDATA_NAK: act = ACT_END;
        default:      act = ACT_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_count.sv
module i2c_seq_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LEN_W-1:0] clr_limit,
  input  logic             inc,
  output logic [LEN_W-1:0] count,
  output logic             room
);
  logic [LEN_W-1:0] count_q, count_d, limit_q;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = clr ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
    end else begin
      if (count_en) count_q <= count_d;
      if (clr)      limit_q <= clr_limit;
    end
  end

  assign count = count_q;
  assign room  = count_q < limit_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> room);
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit_q);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [6:0]       req_addr,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] xfer_count,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_ack,
  output logic             ctl_load,
  output logic [7:0]       ctl_wdata,
  input  logic             ctl_event,
  input  logic [7:0]       ctl_status,
  input  logic [7:0]       ctl_rdata
);
  logic      rst_sync_n;
  sq_state_e state_q, state_d;
  sq_act_e   act;
  logic      room, cnt_clr, cnt_inc, accept;
  logic [6:0] addr_q;
  logic      rd_q;
  logic      start_q, start_d, stop_q, stop_d, load_q, load_d;
  logic      ack_q, ack_d, rxv_q, rxv_d, done_q, done_d, err_q, err_d;
  logic [7:0] wdata_q, wdata_d, rxd_q, rxd_d;

  i2c_seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  i2c_seq_decode u_dec (.status(ctl_status), .is_read(rd_q), .room(room), .act(act));

  i2c_seq_count #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .clr_limit(req_len),
    .inc(cnt_inc), .count(xfer_count), .room(room)
  );

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    load_d  = 1'b0;
    rxv_d   = 1'b0;
    done_d  = 1'b0;
    wdata_d = wdata_q;
    rxd_d   = rxd_q;
    ack_d   = ack_q;
    err_d   = err_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    accept  = 1'b0;
    case (state_q)
      SQ_IDLE: if (req_valid) begin
        accept  = 1'b1;
        cnt_clr = 1'b1;
        start_d = 1'b1;
        ack_d   = 1'b0;
        err_d   = 1'b0;
        state_d = SQ_WAIT;
      end
      SQ_WAIT: if (ctl_event) begin
        case (act)
          ACT_ADDR:    begin load_d = 1'b1; wdata_d = {addr_q, rd_q}; end
          ACT_SEND:    state_d = SQ_FETCH;
          ACT_ACK_ON:  ack_d = 1'b1;
          ACT_RX_KEEP: begin rxv_d = 1'b1; rxd_d = ctl_rdata; cnt_inc = 1'b1; ack_d = 1'b1; end
          ACT_RX_DROP: ack_d = 1'b0;
          ACT_END:     begin stop_d = 1'b1; done_d = 1'b1; state_d = SQ_IDLE; end
          default:     begin stop_d = 1'b1; done_d = 1'b1; err_d = 1'b1; state_d = SQ_IDLE; end
        endcase
      end
      SQ_FETCH: if (tx_valid) begin
        load_d  = 1'b1;
        wdata_d = tx_data;
        cnt_inc = 1'b1;
        state_d = SQ_WAIT;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SQ_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      load_q  <= 1'b0;
      rxv_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      rxd_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      load_q  <= load_d;
      rxv_q   <= rxv_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      wdata_q <= wdata_d;
      rxd_q   <= rxd_d;
      if (accept) begin
        addr_q <= req_addr;
        rd_q   <= req_read;
      end
    end
  end

  assign busy      = state_q != SQ_IDLE;
  assign tx_ready  = state_q == SQ_FETCH;
  assign done      = done_q;
  assign err       = err_q;
  assign rx_valid  = rxv_q;
  assign rx_data   = rxd_q;
  assign ctl_start = start_q;
  assign ctl_stop  = stop_q;
  assign ctl_ack   = ack_q;
  assign ctl_load  = load_q;
  assign ctl_wdata = wdata_q;

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> ctl_start);
  // R10
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (ctl_stop && !busy));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);
  // R3
  tx_dir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_ready |-> !rd_q);
  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err) |-> done);
  // R7
  rx_ack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |-> ctl_ack);
endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
  localparam int LEN_W = 4;
  localparam int NVEC = 9;
  // {read, addr[6:0], len[3:0], fault position (15 = none)}
  localparam logic [15:0] VECS [NVEC] = '{
    {1'b0, 7'h50, 4'd3,  4'hF},
    {1'b0, 7'h2A, 4'd0,  4'hF},
    {1'b1, 7'h68, 4'd2,  4'hF},
    {1'b1, 7'h11, 4'd0,  4'hF},
    {1'b0, 7'h7F, 4'd15, 4'hF},
    {1'b0, 7'h22, 4'd4,  4'd2},
    {1'b1, 7'h33, 4'd5,  4'd3},
    {1'b1, 7'h01, 4'd1,  4'hF},
    {1'b0, 7'h40, 4'd2,  4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [6:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic busy, done, err, tx_ready, rx_valid;
  logic [LEN_W-1:0] xfer_count;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic ctl_start, ctl_stop, ctl_ack, ctl_load;
  logic [7:0] ctl_wdata;
  logic ctl_event = 1'b0;
  logic [7:0] ctl_status = '0, ctl_rdata = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  i2c_xfer_seq #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_read(req_read), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .xfer_count(xfer_count), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .ctl_ack(ctl_ack), .ctl_load(ctl_load), .ctl_wdata(ctl_wdata), .ctl_event(ctl_event),
    .ctl_status(ctl_status), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [7:0] s, input logic [7:0] d);
    ctl_event = 1'b1; ctl_status = s; ctl_rdata = d;
    @(negedge clk);
    ctl_event = 1'b0;
  endtask

  task automatic request(input logic rd, input logic [6:0] a, input logic [3:0] n);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_len = n;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 start pulse", ctl_start, 1);
    chk("R1 busy high", busy, 1);
    chk("R10 err cleared", err, 0);
    chk("R10 count cleared", xfer_count, 0);
    ev(8'h08, 8'h00);
    chk("R2 addr load", ctl_load, 1);
    chk("R2 addr byte", ctl_wdata, {a, rd});
  endtask

  task automatic feed(input logic [7:0] b, input int delay);
    chk("R3 tx_ready", tx_ready, 1);
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk("R3 waits for tx_valid", ctl_load, 0);
    end
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R3 data load", ctl_load, 1);
    chk("R3 data byte", ctl_wdata, b);
    chk("R3 tx_ready drops", tx_ready, 0);
  endtask

  task automatic check_end(input string tag, input logic e, input int n);
    chk({tag, " done"}, done, 1);
    chk({tag, " stop"}, ctl_stop, 1);
    chk({tag, " busy low"}, busy, 0);
    chk({tag, " err"}, err, e);
    chk({tag, " count"}, xfer_count, n);
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic rd; logic [6:0] a; int n, f;
    rd = v[15]; a = v[14:8]; n = v[7:4]; f = v[3:0];
    request(rd, a, v[7:4]);
    if (!rd) begin
      for (int i = 0; i < n; i++) begin
        if (f == i) begin
          ev(i == 0 ? 8'h20 : 8'h30, 8'h00);
          check_end("R9 write fault", 1'b1, i);
          return;
        end
        ev(i == 0 ? 8'h18 : 8'h28, 8'h00);
        feed(8'(a ^ (i * 37)), i % 3);
      end
      ev(n == 0 ? 8'h18 : 8'h28, 8'h00);
      if (n == 0) check_end("R5 zero-length write", 1'b0, 0);
      else        check_end("R4 write end", 1'b0, n);
    end else begin
      ev(8'h40, 8'h00);
      chk("R6 ack on", ctl_ack, 1);
      for (int i = 0; i < n; i++) begin
        if (f == i) begin
          ev(8'h18, 8'h00);
          check_end("R9 read fault", 1'b1, i);
          return;
        end
        ev(8'h50, 8'(~a + i * 13));
        chk("R7 rx_valid", rx_valid, 1);
        chk("R7 rx_data", rx_data, 8'(~a + i * 13));
        chk("R7 ack kept", ctl_ack, 1);
      end
      ev(8'h50, 8'hEE);
      chk("R7 no room rx_valid", rx_valid, 0);
      chk("R7 no room ack cleared", ctl_ack, 0);
      chk("R7 no room count", xfer_count, n);
      ev(8'h58, 8'h00);
      check_end("R8 read end", 1'b0, n);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R6 reset ack", ctl_ack, 0);
    chk("R3 reset tx_ready", tx_ready, 0);

    for (int j = 0; j < NVEC; j++) begin
      run_vec(VECS[j]);
      @(negedge clk);
      chk("R10 done one cycle", done, 0);
      chk("R10 count held", xfer_count, (VECS[j][3:0] != 4'hF) ? int'(VECS[j][3:0]) : int'(VECS[j][7:4]));
      chk("R10 err held", err, VECS[j][3:0] != 4'hF);
    end

    // R11: request while busy is ignored
    request(1'b0, 7'h15, 4'd1);
    req_valid = 1'b1; req_read = 1'b1; req_addr = 7'h66; req_len = 4'd2;
    @(negedge clk);
    chk("R11 no start while busy", ctl_start, 0);
    @(negedge clk);
    chk("R11 no start while busy", ctl_start, 0);
    req_valid = 1'b0;
    ev(8'h18, 8'h00);
    feed(8'hA5, 0);
    ev(8'h28, 8'h00);
    check_end("R11 running write intact", 1'b0, 1);

    // R9: read-direction code during a write
    @(negedge clk);
    request(1'b0, 7'h3C, 4'd1);
    ev(8'h40, 8'h00);
    check_end("R9 wrong-direction code", 1'b1, 0);
    chk("R9 no tx_ready", tx_ready, 0);

    // R10: next request clears err and count
    @(negedge clk);
    request(1'b1, 7'h09, 4'd1);
    ev(8'h40, 8'h00);
    ev(8'h50, 8'h5A);
    chk("R7 rx_data", rx_data, 8'h5A);
    ev(8'h58, 8'h00);
    check_end("R8 read after fault", 1'b0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule